// File: doc/BRIEF.md
# Host Default Control Endpoint Status Logic

This block holds the control and status state for the default control pipe of a USB controller working as host. Software sees one 8-bit register, written and read over a plain strobe-and-data bus. Software arms a request by writing that byte. The block then offers one transaction at a time to an external transaction engine. Each offer carries a token class and the data-toggle value the packet must use. The engine reports the outcome as one-cycle strobes, and the block folds each outcome back into the byte.

Several side effects live in the register write. Arming a SETUP forces DATA0, and arming a status stage forces DATA1. The toggle then advances only on success. A retry counter and a frame-based NAK timer watch the endpoint. The timeout, error and stall flags are sticky and freeze all new offers until software writes them back to 0. Outcomes that need attention raise a one-cycle interrupt pulse.

Top module: `usb_ep0_host_ctl`

## Requirements
- R1: After reset the register byte reads 0x00, the toggle output is 0, and neither `txn_start` nor `ep0_irq` is asserted.
- R2: Bits 7 (NAK timeout), 4 (error), 2 (stalled) and 0 (receive ready) are cleared only by a software write of 0 to that bit. Writing 1 to any of them leaves it unchanged.
- R3: A write with both bit 3 (setup) and bit 1 (transmit ready) set makes the toggle 0 and offers token class SETUP. A write of bit 3 without bit 1 leaves bit 3 and the toggle unchanged.
- R4: A write of bit 6 (status stage) together with bit 1 or bit 5 (request IN) makes the toggle 1 and asserts `txn_status`. Hardware clears bit 6 when that transaction completes. Bit 6 written alone is ignored.
- R5: `txn_start` is a one-cycle offer. It is raised when bit 1 or bit 5 is pending, no transaction is outstanding, and no blocking flag is set. `txn_kind` is 0 for OUT, 1 for SETUP and 2 for IN, and a pending bit 1 takes priority over bit 5.
- R6: An accepted IN packet sets bit 0 and clears bit 5 in the same cycle.
- R7: An ACK for an outgoing transaction clears bits 1, 3 and 6.
- R8: The toggle inverts on an ACK or on an accepted IN packet. It is unchanged by NAK, no-response or STALL.
- R9: The third consecutive no-response outcome sets bit 4 and pulses `ep0_irq` in the same cycle. The first two outcomes only cause a re-offer.
- R10: Any handshake (NAK included) and any newly armed request reset the retry count.
- R11: A STALL outcome sets bit 2.
- R12: After a NAK, bit 7 sets once `nak_limit` frame ticks pass with no completion. A limit of 0 disables the timeout.
- R13: While bit 7, 4 or 2 is set, no offer is made and a pending bit 1 or 5 is kept. Clearing the blocking bit resumes offers.
- R14: `ep0_irq` pulses for one cycle on ACK, accepted IN packet, STALL, error and NAK timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Current register byte |
| nak_limit | input | LIMIT_W | NAK timeout in frames, 0 disables |
| sof_tick | input | 1 | One pulse per frame |
| ev_ack | input | 1 | ACK received for an outgoing transaction |
| ev_rx | input | 1 | IN data packet accepted |
| ev_nak | input | 1 | NAK received |
| ev_noresp | input | 1 | No response from device |
| ev_stall | input | 1 | STALL received |
| txn_start | output | 1 | Transaction offer strobe |
| txn_kind | output | 2 | Token class: 0 OUT, 1 SETUP, 2 IN |
| txn_status | output | 1 | Offer belongs to a status stage |
| txn_toggle | output | 1 | Data toggle to use (0 DATA0, 1 DATA1) |
| ep0_irq | output | 1 | Endpoint interrupt pulse |

## Verification
A wrong toggle is visible on `txn_toggle` at the next offer, one cycle after the write or outcome that set it. A lost or extra retry count shows up on the third no-response outcome: bit 4 is missing or appears too early, read back in the cycle after the strobe. A stuck outstanding-transaction flag, or one that is never cleared, appears within a cycle as a missing re-offer or an offer made while a blocking flag reads 1. The NAK timer is seen on bit 7 only at the exact frame tick that reaches the limit.

// File: rtl/ep0_host_pkg.sv
// Package: bit positions of the endpoint register and token classes.
// Assumes: the register byte layout is fixed, because the issue logic decodes it.
package ep0_host_pkg;
    localparam int B_RXRDY = 0;
    localparam int B_TXRDY = 1;
    localparam int B_STALL = 2;
    localparam int B_SETUP = 3;
    localparam int B_ERR   = 4;
    localparam int B_REQIN = 5;
    localparam int B_STAT  = 6;
    localparam int B_NAKTO = 7;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_SETUP = 2'd1,
        TK_IN    = 2'd2
    } ep0_tok_e;
endpackage

// File: rtl/ep0_csr_reg.sv
// Module: endpoint register byte and data-toggle bit.
// Merges software writes with hardware outcome strobes; the hardware
// outcomes are applied after the write in the same cycle.
// Assumes: outcome strobes are already gated to an outstanding transaction.
module ep0_csr_reg
    import ep0_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       hw_ack,
    input  logic       hw_rx,
    input  logic       stall_set,
    input  logic       err_set,
    input  logic       nakto_set,
    output logic [7:0] csr,
    output logic       toggle
);
    logic [7:0] csr_nxt;
    logic       tog_nxt;
    logic       arm;

    assign arm = wdata[B_TXRDY] | wdata[B_REQIN];

    // Next register byte: software write first, then hardware outcomes.
    always_comb begin
        csr_nxt = csr;
        if (we) begin
            csr_nxt[B_NAKTO] = csr[B_NAKTO] & wdata[B_NAKTO];
            csr_nxt[B_ERR]   = csr[B_ERR]   & wdata[B_ERR];
            csr_nxt[B_STALL] = csr[B_STALL] & wdata[B_STALL];
            csr_nxt[B_RXRDY] = csr[B_RXRDY] & wdata[B_RXRDY];
            csr_nxt[B_TXRDY] = wdata[B_TXRDY];
            csr_nxt[B_REQIN] = wdata[B_REQIN];
            csr_nxt[B_SETUP] = wdata[B_TXRDY] ? wdata[B_SETUP] : csr[B_SETUP];
            csr_nxt[B_STAT]  = arm ? wdata[B_STAT] : csr[B_STAT];
        end
        if (hw_ack) begin
            csr_nxt[B_TXRDY] = 1'b0;
            csr_nxt[B_SETUP] = 1'b0;
            csr_nxt[B_STAT]  = 1'b0;
        end
        if (hw_rx) begin
            csr_nxt[B_RXRDY] = 1'b1;
            csr_nxt[B_REQIN] = 1'b0;
            csr_nxt[B_STAT]  = 1'b0;
        end
        if (stall_set) csr_nxt[B_STALL] = 1'b1;
        if (err_set)   csr_nxt[B_ERR]   = 1'b1;
        if (nakto_set) csr_nxt[B_NAKTO] = 1'b1;
    end

    // Next toggle: forced by setup or status arming, inverted on success.
    always_comb begin
        tog_nxt = toggle;
        if (we) begin
            if (wdata[B_SETUP] && wdata[B_TXRDY]) tog_nxt = 1'b0;
            else if (wdata[B_STAT] && arm)        tog_nxt = 1'b1;
        end
        if (hw_ack || hw_rx) tog_nxt = ~tog_nxt;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr    <= '0;
            toggle <= 1'b0;
        end else begin
            csr    <= csr_nxt;
            toggle <= tog_nxt;
        end
    end
endmodule

// File: rtl/ep0_retry_nak.sv
// Module: consecutive no-response counter and frame-based NAK timer.
// Assumes: strobes are gated to an outstanding transaction; sof_tick is one
// cycle per frame; a limit of 0 disables the timer.
module ep0_retry_nak #(
    parameter int RETRY_MAX = 3,
    parameter int LIMIT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               hw_ack,
    input  logic               hw_rx,
    input  logic               hw_nak,
    input  logic               hw_noresp,
    input  logic               hw_stall,
    input  logic               sof_tick,
    input  logic [LIMIT_W-1:0] nak_limit,
    output logic               err_set,
    output logic               nakto_set
);
    localparam int RW = $clog2(RETRY_MAX + 1);

    logic [RW-1:0]      retry_q;
    logic [LIMIT_W-1:0] frames_q;
    logic               nak_run;
    logic               lim_on;

    assign lim_on    = (nak_limit != '0);
    assign err_set   = hw_noresp && (retry_q == RW'(RETRY_MAX - 1));
    assign nakto_set = nak_run && sof_tick && lim_on &&
                       (frames_q == nak_limit - LIMIT_W'(1));

    // Retry count: reset by any handshake or a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= '0;
        end else if (restart || hw_ack || hw_rx || hw_nak || hw_stall || err_set) begin
            retry_q <= '0;
        end else if (hw_noresp) begin
            retry_q <= retry_q + RW'(1);
        end
    end

    // NAK timer: armed by a NAK, counts frames until completion or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_run  <= 1'b0;
            frames_q <= '0;
        end else if (restart || hw_ack || hw_rx || hw_stall || nakto_set) begin
            nak_run  <= 1'b0;
            frames_q <= '0;
        end else begin
            if (hw_nak) nak_run <= 1'b1;
            if (nak_run && sof_tick && lim_on) frames_q <= frames_q + LIMIT_W'(1);
        end
    end
endmodule

// File: rtl/ep0_issue.sv
// Module: offers one transaction at a time and tracks the outstanding one.
// Assumes: the engine answers each offer with exactly one outcome strobe.
module ep0_issue
    import ep0_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txrdy,
    input  logic       reqin,
    input  logic       setup,
    input  logic       stat,
    input  logic       blocked,
    input  logic       done,
    input  logic       abort,
    output logic       inflight,
    output logic       start,
    output logic [1:0] kind,
    output logic       status
);
    ep0_tok_e tok;

    assign start  = !inflight && (txrdy || reqin) && !blocked;
    assign status = stat;
    assign kind   = tok;

    // Token class: a pending transmit outranks a pending IN request.
    always_comb begin
        if (txrdy) tok = setup ? TK_SETUP : TK_OUT;
        else       tok = TK_IN;
    end

    // Outstanding-transaction flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              inflight <= 1'b0;
        else if (start)          inflight <= 1'b1;
        else if (done || abort)  inflight <= 1'b0;
    end
endmodule

// File: rtl/usb_ep0_host_ctl.sv
// Module: control and status logic of the host's default control endpoint.
// Gates engine outcomes to the outstanding transaction, and wires together
// the register, the retry/NAK timers and the offer logic.
// Assumes: synchronous active-low reset; outcome strobes last one cycle.
module usb_ep0_host_ctl
    import ep0_host_pkg::*;
#(
    parameter int RETRY_MAX = 3,
    parameter int LIMIT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [7:0]         csr_wdata,
    output logic [7:0]         csr_rdata,
    input  logic [LIMIT_W-1:0] nak_limit,
    input  logic               sof_tick,
    input  logic               ev_ack,
    input  logic               ev_rx,
    input  logic               ev_nak,
    input  logic               ev_noresp,
    input  logic               ev_stall,
    output logic               txn_start,
    output logic [1:0]         txn_kind,
    output logic               txn_status,
    output logic               txn_toggle,
    output logic               ep0_irq
);
    logic [7:0] csr;
    logic       inflight;
    logic       g_ack, g_rx, g_nak, g_noresp, g_stall;
    logic       err_set, nakto_set, restart, blocked;

    assign g_ack    = ev_ack    & inflight;
    assign g_rx     = ev_rx     & inflight;
    assign g_nak    = ev_nak    & inflight;
    assign g_noresp = ev_noresp & inflight;
    assign g_stall  = ev_stall  & inflight;
    assign restart  = csr_we & (csr_wdata[B_TXRDY] | csr_wdata[B_REQIN]);
    assign blocked  = csr[B_NAKTO] | csr[B_ERR] | csr[B_STALL];
    assign csr_rdata = csr;

    ep0_csr_reg u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
        .hw_ack(g_ack), .hw_rx(g_rx), .stall_set(g_stall),
        .err_set(err_set), .nakto_set(nakto_set),
        .csr(csr), .toggle(txn_toggle)
    );

    ep0_retry_nak #(.RETRY_MAX(RETRY_MAX), .LIMIT_W(LIMIT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .hw_ack(g_ack), .hw_rx(g_rx), .hw_nak(g_nak),
        .hw_noresp(g_noresp), .hw_stall(g_stall),
        .sof_tick(sof_tick), .nak_limit(nak_limit),
        .err_set(err_set), .nakto_set(nakto_set)
    );

    ep0_issue u_iss (
        .clk(clk), .rst_n(rst_n),
        .txrdy(csr[B_TXRDY]), .reqin(csr[B_REQIN]),
        .setup(csr[B_SETUP]), .stat(csr[B_STAT]),
        .blocked(blocked),
        .done(g_ack | g_rx | g_nak | g_noresp | g_stall),
        .abort(nakto_set),
        .inflight(inflight), .start(txn_start),
        .kind(txn_kind), .status(txn_status)
    );

    // Interrupt pulse on outcomes that need software attention.
    always_ff @(posedge clk) begin
        if (!rst_n) ep0_irq <= 1'b0;
        else        ep0_irq <= g_ack | g_rx | g_stall | err_set | nakto_set;
    end
endmodule

// File: rtl/ep0_host_chk.sv
// Module: port-level properties of the endpoint logic, bound to the top.
module ep0_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csr_we,
    input logic [7:0] csr_wdata,
    input logic [7:0] csr_rdata,
    input logic       ev_ack,
    input logic       ev_rx,
    input logic       txn_start,
    input logic       txn_toggle,
    input logic       ep0_irq
);
    // R13: no offer while a blocking flag reads 1.
    a_r13_no_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> !(csr_rdata[7] | csr_rdata[4] | csr_rdata[2]));

    // R3: setup arming gives DATA0.
    a_r3_setup_data0: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_wdata[3] && csr_wdata[1] && !ev_ack && !ev_rx) |=> !txn_toggle);

    // R4: status arming gives DATA1.
    a_r4_status_data1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_wdata[6] && (csr_wdata[1] || csr_wdata[5]) && !csr_wdata[3]
         && !ev_ack && !ev_rx) |=> txn_toggle);

    // R8: toggle holds without a write or a successful outcome.
    a_r8_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_we && !ev_ack && !ev_rx) |=> $stable(txn_toggle));

    // R9: error appears together with the interrupt pulse.
    a_r9_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[4]) |-> ep0_irq);

    // R6: receive ready never rises with request-IN still set.
    a_r6_reqin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[0]) |-> !csr_rdata[5]);

    // R11: stalled stays until a write of 0.
    a_r11_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[2] && !(csr_we && !csr_wdata[2])) |=> csr_rdata[2]);
endmodule

bind usb_ep0_host_ctl ep0_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ev_ack(ev_ack), .ev_rx(ev_rx),
    .txn_start(txn_start), .txn_toggle(txn_toggle), .ep0_irq(ep0_irq)
);

// File: tb/usb_ep0_host_ctl_bench.sv
`timescale 1ns/1ps
module usb_ep0_host_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic [4:0] nak_limit = '0;
    logic       sof_tick = 1'b0;
    logic       ev_ack = 1'b0, ev_rx = 1'b0, ev_nak = 1'b0, ev_noresp = 1'b0, ev_stall = 1'b0;
    logic       txn_start, txn_status, txn_toggle, ep0_irq;
    logic [1:0] txn_kind;

    int n_chk = 0;
    int n_fail = 0;

    localparam int E_ACK = 0, E_RX = 1, E_NAK = 2, E_NORESP = 3, E_STALL = 4;

    always #2.5 clk = ~clk;

    usb_ep0_host_ctl u_usb_ep0_host_ctl (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .nak_limit(nak_limit), .sof_tick(sof_tick),
        .ev_ack(ev_ack), .ev_rx(ev_rx), .ev_nak(ev_nak),
        .ev_noresp(ev_noresp), .ev_stall(ev_stall),
        .txn_start(txn_start), .txn_kind(txn_kind), .txn_status(txn_status),
        .txn_toggle(txn_toggle), .ep0_irq(ep0_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic ev(input int which);
        case (which)
            E_ACK:    ev_ack = 1'b1;
            E_RX:     ev_rx = 1'b1;
            E_NAK:    ev_nak = 1'b1;
            E_NORESP: ev_noresp = 1'b1;
            default:  ev_stall = 1'b1;
        endcase
        @(negedge clk);
        ev_ack = 1'b0; ev_rx = 1'b0; ev_nak = 1'b0; ev_noresp = 1'b0; ev_stall = 1'b0;
    endtask

    task automatic sof();
        sof_tick = 1'b1;
        @(negedge clk);
        sof_tick = 1'b0;
    endtask

    // Wait for an offer, check it, step into the outstanding cycle, answer it.
    task automatic answer(input int which, input string tag);
        bit got = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (txn_start) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, tag, int'(got), 1);
        @(negedge clk);
        ev(which);
    endtask

    task automatic t_reset();
        chk(csr_rdata == 8'h00, "R1 byte", csr_rdata, 0);
        chk(!txn_toggle && !txn_start && !ep0_irq, "R1 outputs",
            {txn_toggle, txn_start, ep0_irq}, 0);
    endtask

    task automatic t_out_ack();
        wr(8'h02);
        chk(txn_start && txn_kind == 2'd0 && !txn_status, "R5 OUT offer",
            {txn_start, txn_kind, txn_status}, 4'b1000);
        @(negedge clk);
        ev(E_ACK);
        chk(csr_rdata == 8'h00, "R7 ack clears", csr_rdata, 0);
        chk(ep0_irq, "R14 irq on ack", ep0_irq, 1);
        chk(txn_toggle, "R8 flip on ack", txn_toggle, 1);
    endtask

    task automatic t_setup();
        wr(8'h08);
        chk(csr_rdata == 8'h00 && !txn_start && txn_toggle, "R3 setup alone ignored",
            {csr_rdata, txn_start, txn_toggle}, 10'h001);
        wr(8'h0A);
        chk(!txn_toggle, "R3 setup DATA0", txn_toggle, 0);
        chk(txn_start && txn_kind == 2'd1, "R3 SETUP token", txn_kind, 1);
        @(negedge clk);
        ev(E_ACK);
        chk(csr_rdata == 8'h00 && txn_toggle, "R7 setup ack", {csr_rdata, txn_toggle}, 9'h001);
    endtask

    task automatic t_status_in();
        wr(8'h02);
        answer(E_ACK, "R5 offer");
        chk(!txn_toggle, "R8 toggle now 0", txn_toggle, 0);
        wr(8'h40);
        chk(csr_rdata == 8'h00 && !txn_toggle, "R4 status alone ignored",
            {csr_rdata, txn_toggle}, 0);
        wr(8'h60);
        chk(txn_toggle && txn_status, "R4 status DATA1", {txn_toggle, txn_status}, 3);
        chk(txn_start && txn_kind == 2'd2, "R5 IN offer", txn_kind, 2);
        @(negedge clk);
        ev(E_RX);
        chk(csr_rdata == 8'h01, "R6 rx sets rxrdy clears reqin/status", csr_rdata, 1);
        chk(!txn_toggle && ep0_irq, "R8 flip on rx", {txn_toggle, ep0_irq}, 1);
        wr(8'h00);
        chk(csr_rdata == 8'h00, "R2 write 0 clears rxrdy", csr_rdata, 0);
        wr(8'h01);
        chk(csr_rdata == 8'h00, "R2 write 1 ignored", csr_rdata, 0);
    endtask

    task automatic t_no_flip();
        wr(8'h02);
        answer(E_NAK, "R5 offer");
        chk(!txn_toggle && csr_rdata == 8'h02 && !ep0_irq, "R8 nak no flip",
            {txn_toggle, csr_rdata, ep0_irq}, 10'h004);
        answer(E_NORESP, "R5 reoffer after nak");
        chk(!txn_toggle, "R8 noresp no flip", txn_toggle, 0);
        answer(E_ACK, "R5 reoffer after noresp");
        chk(txn_toggle, "R8 flip after ack", txn_toggle, 1);
    endtask

    task automatic t_retry();
        bit seen = 1'b0;
        wr(8'h02);
        answer(E_NORESP, "R9 try1");
        answer(E_NORESP, "R9 try2");
        chk(csr_rdata == 8'h02, "R9 no error after two", csr_rdata, 2);
        answer(E_NORESP, "R9 try3");
        chk(csr_rdata == 8'h12, "R9 error after three", csr_rdata, 8'h12);
        chk(ep0_irq, "R9 irq with error", ep0_irq, 1);
        for (int i = 0; i < 4; i++) begin
            if (txn_start) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R13 blocked by error", seen, 0);
        wr(8'h12);
        chk(csr_rdata == 8'h12, "R2 error write 1 keeps", csr_rdata, 8'h12);
        wr(8'h02);
        chk(csr_rdata == 8'h02 && txn_start, "R13 resumes after clear",
            {csr_rdata, txn_start}, 9'h005);
        answer(E_ACK, "R13 offer");
        chk(csr_rdata == 8'h00, "R7 done", csr_rdata, 0);
    endtask

    task automatic t_retry_reset();
        wr(8'h02);
        answer(E_NORESP, "R10 a");
        answer(E_NORESP, "R10 b");
        answer(E_NAK, "R10 c");
        answer(E_NORESP, "R10 d");
        answer(E_NORESP, "R10 e");
        chk(csr_rdata == 8'h02, "R10 nak resets retries", csr_rdata, 2);
        answer(E_ACK, "R10 f");
    endtask

    task automatic t_stall();
        bit seen = 1'b0;
        wr(8'h20);
        answer(E_STALL, "R11 offer");
        chk(csr_rdata == 8'h24, "R11 stalled set", csr_rdata, 8'h24);
        chk(ep0_irq, "R14 irq on stall", ep0_irq, 1);
        wr(8'h24);
        chk(csr_rdata == 8'h24, "R2 stall write 1 keeps", csr_rdata, 8'h24);
        for (int i = 0; i < 3; i++) begin
            if (txn_start) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R13 blocked by stall", seen, 0);
        wr(8'h20);
        answer(E_RX, "R13 resume after stall");
        chk(csr_rdata == 8'h01, "R6 rx after stall", csr_rdata, 1);
        wr(8'h00);
    endtask

    task automatic t_nakto();
        bit seen = 1'b0;
        nak_limit = 5'd3;
        wr(8'h02);
        answer(E_NAK, "R12 offer");
        sof();
        sof();
        chk(csr_rdata == 8'h02, "R12 not yet timed out", csr_rdata, 2);
        sof();
        chk(csr_rdata == 8'h82, "R12 timeout at limit", csr_rdata, 8'h82);
        chk(ep0_irq, "R14 irq on timeout", ep0_irq, 1);
        for (int i = 0; i < 3; i++) begin
            if (txn_start) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R13 blocked by timeout", seen, 0);
        wr(8'h02);
        answer(E_ACK, "R13 resume after timeout");
        chk(csr_rdata == 8'h00, "R12 cleared", csr_rdata, 0);
    endtask

    task automatic t_nak_off();
        nak_limit = 5'd0;
        wr(8'h02);
        answer(E_NAK, "R12 offer");
        for (int i = 0; i < 40; i++) sof();
        chk(csr_rdata == 8'h02, "R12 limit 0 disables", csr_rdata, 2);
        ev(E_ACK);
        chk(csr_rdata == 8'h00, "R7 ack after long nak", csr_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out_ack();
        t_setup();
        t_status_in();
        t_no_flip();
        t_retry();
        t_retry_reset();
        t_stall();
        t_nakto();
        t_nak_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule